// File: doc/BRIEF.md
# Fuse Array Direct Pin Controller

This block lets software drive the control pins of a one-time-programmable fuse array directly, one pin at a time. It holds a latched level for four pins: program enable, chip select, strobe and load. It also holds a 16-bit address for the array's address pins.

Pins are raised through a dedicated set port and lowered through a separate clear port. Each port takes a bit mask, so software never has to read the pin state, modify it and write it back. The strobe has no clear bit. Instead, an optional down-counter drops it after a programmed number of clocks, so the pulse width is exact and does not depend on software timing.

Nothing reaches the pins unless two configuration bits are both high: the module enable and the direct-path enable. Leaving that mode returns every pin to its inactive level and discards the latched state. A small configuration port sets the mode bits, the address and the strobe timer, and reads them back.

Top module: `fuse_pin_ctrl`

## Requirements
- R1: After reset all configuration fields read 0. The pins are inactive: `fuse_pgm_n`=1, `fuse_cs_n`=1, `fuse_strobe`=0, `fuse_load`=0, and `fuse_addr`=0.
- R2: A set-port write raises a pin for each mask bit that is 1: bit 0 program enable, bit 1 chip select, bit 2 strobe, bit 3 load. Mask bits that are 0 leave their pin unchanged. The change is visible after the clock edge that samples the write.
- R3: A clear-port write lowers a pin for each mask bit that is 1: bit 0 program enable, bit 1 chip select, bit 3 load. Bit 2 is ignored, so the strobe is never lowered by this port.
- R4: When the set and clear ports both target the same pin in the same cycle, the clear takes effect.
- R5: Direct mode is active only while configuration register 0 has bit 0 (module enable) and bit 1 (direct-path enable) both set. While direct mode is inactive, set and clear writes have no effect.
- R6: After the edge that makes direct mode inactive, all four pins show their inactive levels. The latched state is discarded, so turning direct mode back on shows all pins inactive.
- R7: Program enable and chip select are active low at the ports. Load and strobe are active high.
- R8: Configuration register 2 holds a strobe count N in bits 8:0 and an auto-release enable in bit 9. With auto-release enabled, a strobe set holds `fuse_strobe` high for N clocks (one clock when N is 0 or 1). Setting the strobe again while it is high reloads N.
- R9: With auto-release disabled, the strobe stays high until direct mode is left.
- R10: Configuration register 1 holds a 16-bit address. `fuse_addr` carries that address while direct mode is active and 0 otherwise.
- R11: `cfg_rdata` returns the register selected by `cfg_addr` without delay: register 0 holds the two mode bits, register 1 the address, register 2 the strobe settings. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select, for both write and read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| set_we | input | 1 | Set-port write strobe |
| set_mask | input | 4 | Pins to raise |
| clr_we | input | 1 | Clear-port write strobe |
| clr_mask | input | 4 | Pins to lower (bit 2 ignored) |
| fuse_pgm_n | output | 1 | Program enable, active low |
| fuse_cs_n | output | 1 | Chip select, active low |
| fuse_strobe | output | 1 | Strobe, active high |
| fuse_load | output | 1 | Load, active high |
| fuse_addr | output | 16 | Fuse array address |

## Verification
Set and clear writes appear on the pins one edge after they are sampled. A configuration write changes `fuse_addr`, the pin gating and `cfg_rdata` after that same edge. The latched pin state is dropped one edge later still. A strobe set at edge E0 with count N falls at edge E0+N.

The bench drives its inputs on falling edges and samples on the next falling edge, so exactly one rising edge separates each stimulus from its check. The strobe width is measured by counting falling edges while the strobe is high. The bench sweeps every combination of initial pin state, set mask and clear mask.

// File: rtl/fuse_pin_ctrl.sv
module fuse_pin_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              set_we,
  input  logic [3:0]        set_mask,
  input  logic              clr_we,
  input  logic [3:0]        clr_mask,
  output logic              fuse_pgm_n,
  output logic              fuse_cs_n,
  output logic              fuse_strobe,
  output logic              fuse_load,
  output logic [ADDR_W-1:0] fuse_addr
);

  localparam int PAD_W = 32 - CNT_W - 1;
  localparam int AD_PAD = 32 - ADDR_W;

  logic              mod_en, dir_en, auto_en;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_cfg, cnt_q;
  logic [3:0]        pins_q, pins_nxt, set_v, clr_v;
  logic              active, st_drop;

  assign active  = mod_en & dir_en;
  assign set_v   = set_we ? set_mask : 4'b0000;
  assign clr_v   = clr_we ? {clr_mask[3], 1'b0, clr_mask[1:0]} : 4'b0000;
  assign st_drop = pins_q[2] & auto_en & (cnt_q <= CNT_W'(1)) & ~set_v[2];

  always_comb begin
    pins_nxt    = (pins_q | set_v) & ~clr_v;
    pins_nxt[2] = (pins_q[2] & ~st_drop) | set_v[2];
    if (!active) pins_nxt = 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en  <= 1'b0;
      dir_en  <= 1'b0;
      auto_en <= 1'b0;
      addr_q  <= '0;
      cnt_cfg <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: {dir_en, mod_en} <= cfg_wdata[1:0];
        3'd1: addr_q <= cfg_wdata[ADDR_W-1:0];
        3'd2: {auto_en, cnt_cfg} <= cfg_wdata[CNT_W:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= 4'b0000;
      cnt_q  <= '0;
    end else begin
      pins_q <= pins_nxt;
      if (!active) cnt_q <= '0;
      else if (set_v[2]) cnt_q <= cnt_cfg;
      else if (pins_q[2] && auto_en && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {30'd0, dir_en, mod_en};
      3'd1:    cfg_rdata = {{AD_PAD{1'b0}}, addr_q};
      3'd2:    cfg_rdata = {{PAD_W{1'b0}}, auto_en, cnt_cfg};
      default: cfg_rdata = 32'd0;
    endcase
  end

  assign fuse_pgm_n  = ~(pins_q[0] & active);
  assign fuse_cs_n   = ~(pins_q[1] & active);
  assign fuse_strobe = pins_q[2] & active;
  assign fuse_load   = pins_q[3] & active;
  assign fuse_addr   = active ? addr_q : '0;

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && clr_we && clr_mask[1]) |=> fuse_cs_n);

  // R3
  clr_keeps_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pins_q[2] && !auto_en && !cfg_we) |=> pins_q[2]);

  // R6
  off_drops_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pins_q == 4'b0000));

  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pins_q[2] && auto_en && cnt_q <= CNT_W'(1) && !(set_we && set_mask[2]))
    |=> !pins_q[2]);

  // R8
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && set_we && set_mask[2]) |=> (pins_q[2] && cnt_q == $past(cnt_cfg)));

endmodule

// File: tb/test_fuse_pin_ctrl.sv
`timescale 1ns/1ps
module test_fuse_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        set_we = 1'b0;
  logic [3:0]  set_mask = 4'd0;
  logic        clr_we = 1'b0;
  logic [3:0]  clr_mask = 4'd0;
  logic        fuse_pgm_n, fuse_cs_n, fuse_strobe, fuse_load;
  logic [15:0] fuse_addr;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fuse_pin_ctrl i_fuse_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .set_we(set_we),
    .set_mask(set_mask), .clr_we(clr_we), .clr_mask(clr_mask),
    .fuse_pgm_n(fuse_pgm_n), .fuse_cs_n(fuse_cs_n), .fuse_strobe(fuse_strobe),
    .fuse_load(fuse_load), .fuse_addr(fuse_addr));

  function automatic logic [3:0] pins();
    return {fuse_load, fuse_strobe, ~fuse_cs_n, ~fuse_pgm_n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic sw, input logic [3:0] s, input logic cw, input logic [3:0] c);
    @(negedge clk);
    set_we = sw; set_mask = s; clr_we = cw; clr_mask = c;
    @(negedge clk);
    set_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic strobe_width(input int n, output int w);
    w = 0;
    while (fuse_strobe && w < n + 5) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w;
    logic [3:0] exp;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 pins", {28'd0, fuse_load, fuse_strobe, fuse_cs_n, fuse_pgm_n}, 32'h3);
    chk("R1 addr", {16'd0, fuse_addr}, 32'd0);
    for (int a = 0; a < 3; a++) begin
      cfg_addr = 3'(a); #1;
      chk("R1 cfg", cfg_rdata, 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 exhaustive sweep, auto-release off
    cfg(3'd2, 32'd0);
    for (int init = 0; init < 16; init++)
      for (int s = 0; s < 16; s++)
        for (int c = 0; c < 16; c++) begin
          cfg(3'd0, 32'd1);
          cfg(3'd0, 32'd3);
          pulse(1'b1, 4'(init), 1'b0, 4'd0);
          chk("R2 set", {28'd0, pins()}, {28'd0, 4'(init)});
          pulse(1'b1, 4'(s), 1'b1, 4'(c));
          exp = (4'(init) | 4'(s)) & ~{c[3], 1'b0, c[1], c[0]};
          chk("R3 R4 set/clear", {28'd0, pins()}, {28'd0, exp});
        end

    // R7 active-low pin levels
    cfg(3'd0, 32'd1); cfg(3'd0, 32'd3);
    pulse(1'b1, 4'b0011, 1'b0, 4'd0);
    chk("R7 levels", {28'd0, fuse_load, fuse_strobe, fuse_cs_n, fuse_pgm_n}, 32'h0);

    // R3 R9 clear port cannot drop strobe with auto-release off
    pulse(1'b1, 4'b0100, 1'b0, 4'd0);
    pulse(1'b0, 4'd0, 1'b1, 4'hF);
    repeat (10) @(negedge clk);
    chk("R9 strobe held", {31'd0, fuse_strobe}, 32'd1);
    chk("R3 others cleared", {28'd0, pins()}, 32'h4);

    // R6 leaving direct mode
    cfg(3'd0, 32'd1);
    chk("R6 inactive", {28'd0, fuse_load, fuse_strobe, fuse_cs_n, fuse_pgm_n}, 32'h3);
    cfg(3'd0, 32'd3);
    chk("R6 state dropped", {28'd0, pins()}, 32'h0);

    // R5 gating
    for (int m = 0; m < 3; m++) begin
      cfg(3'd0, 32'(m));
      pulse(1'b1, 4'hF, 1'b0, 4'd0);
      chk("R5 gated", {28'd0, pins()}, 32'h0);
    end
    cfg(3'd0, 32'd3);
    chk("R5 nothing latched", {28'd0, pins()}, 32'h0);

    // R8 strobe widths
    for (int n = 0; n <= 20; n++) begin
      cfg(3'd2, 32'h200 | 32'(n));
      pulse(1'b1, 4'b0100, 1'b0, 4'd0);
      strobe_width(n, w);
      chk("R8 width", 32'(w), (n < 1) ? 32'd1 : 32'(n));
    end
    cfg(3'd2, 32'h3FF);
    pulse(1'b1, 4'b0100, 1'b0, 4'd0);
    strobe_width(511, w);
    chk("R8 width max", 32'(w), 32'd511);
    // R8 reload
    cfg(3'd2, 32'h205);
    pulse(1'b1, 4'b0100, 1'b0, 4'd0);
    repeat (2) @(negedge clk);
    pulse(1'b1, 4'b0100, 1'b0, 4'd0);
    strobe_width(5, w);
    chk("R8 reload", 32'(w), 32'd5);

    // R10 R11 address and readback
    cfg(3'd1, 32'h1234_A5C3);
    #1; chk("R11 addr read", cfg_rdata, 32'h0000_A5C3);
    chk("R10 addr on", {16'd0, fuse_addr}, 32'h0000_A5C3);
    cfg_addr = 3'd0; #1; chk("R11 mode read", cfg_rdata, 32'd3);
    cfg_addr = 3'd2; #1; chk("R11 strobe read", cfg_rdata, 32'h205);
    cfg_addr = 3'd5; #1; chk("R11 unmapped", cfg_rdata, 32'd0);
    cfg(3'd0, 32'd2);
    chk("R10 addr off", {16'd0, fuse_addr}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule